// File: doc/BRIEF.md
# Multi-Bank Chip-Select Decoder

This block sits between an internal memory bus and an external memory port. It compares each request address against four programmable banks and drives at most one external chip select. Each bank has a base word, an address mask and an option word. The option word holds the bank's write-protect flag. Each bank also holds four timing words. The timing words are not interpreted here. They are presented next to the chip select of the bank that wins, so that a downstream sequencer can use them.

Software programs the banks through a plain write port made of an address, a data word and an enable. Bank 0 leaves reset already enabled and mapped onto the top 64 KB of the address space, so boot fetches can start before any register is written. A write access that lands in a protected bank is held off from the device, and the block flags it instead. An access that lands in no enabled bank is also flagged. All decode results are registered.

Top module: `csdec_top`

## Requirements
- R1: After reset, bank 0 is enabled with base 0xFFFF0000 and mask 0xFFFF0000. Banks 1 to 3 are disabled, with a zero mask and no write protection. All timing words are zero. While reset is held, every output is zero.
- R2: A bank matches when its enable bit is set and (address AND mask) equals (base AND mask).
- R3: Bits 15:0 of a written base and of a written mask are forced to zero. A bank therefore covers at least 64 KB. A mask of 0xFFFF0000 gives 64 KB, and a mask of zero gives the whole 4 GB space.
- R4: If several enabled banks match, the lowest-numbered bank wins. At most one chip-select bit is ever high, and bit i of cs_o selects bank i.
- R5: A valid request that matches no enabled bank leaves cs_o at zero. It raises nomatch_err_o for exactly one cycle.
- R6: A write request (req_write=1) whose winning bank is protected leaves cs_o at zero and raises wp_err_o for one cycle. A read request to the same bank asserts its chip select.
- R7: On a valid request that has a winning bank (protected or not), bank_o takes that bank's index. tim_o takes that bank's four timing words, with word t at bits [32t+31:32t]. When a request has no winning bank, or when there is no request, both hold their previous values.
- R8: The results of a request appear in the cycle after the clock edge that samples req_valid. In a cycle after an edge with req_valid low, cs_o, wp_err_o and nomatch_err_o are zero.
- R9: The register address is {bank[1:0], sel[2:0]}. The sel values are:
  - 0: base word; bit 0 is the enable bit.
  - 1: mask word.
  - 2: option word; bit 0 is the write-protect flag.
  - 3 to 6: timing words 0 to 3.
  - 7: no register; a write to it has no effect.
- R10: A bank whose enable bit has been cleared never matches, even when its address range covers the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | Request is a write |
| cfg_wr_en | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register address {bank, sel} |
| cfg_wdata | input | 32 | Register write data |
| cs_o | output | 4 | One-hot chip select, registered |
| bank_o | output | 2 | Index of the winning bank |
| tim_o | output | 128 | Timing words of the winning bank |
| wp_err_o | output | 1 | Write-protect violation pulse |
| nomatch_err_o | output | 1 | No-match pulse |

## Verification
Every result of a request is due exactly one clock after the edge that samples req_valid. The bench drives req_valid on a falling edge and compares cs_o, bank_o, tim_o and both error flags on the next falling edge. At that point it also deasserts the request, and one falling edge later it checks that the chip select and the two pulses have returned to zero. A register write takes effect at the edge that samples it, so the bench always lets a full cycle pass between a write and a request that depends on it.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
   // sub-register selector inside one bank's register window
   typedef enum logic [2:0] {
      SEL_BASE = 3'd0,
      SEL_MASK = 3'd1,
      SEL_OPT  = 3'd2,
      SEL_TIM0 = 3'd3
   } csdec_sel_e;

   localparam int SEL_W = 3;

   // mask of address bits kept in base/mask storage
   function automatic logic [31:0] hi_keep(input int aw, input int minl);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < 32; i++)
         if (i >= minl && i < aw) m[i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/csdec_regfile.sv
module csdec_regfile
   import csdec_pkg::*;
#(
   parameter int NB        = 4,
   parameter int AW        = 32,
   parameter int TN        = 4,
   parameter int TW        = 32,
   parameter int MINL      = 16,
   parameter logic [AW-1:0] BOOT_BASE = 32'hFFFF_0000,
   parameter logic [AW-1:0] BOOT_MASK = 32'hFFFF_0000,
   localparam int IDXW     = $clog2(NB),
   localparam int RAW      = IDXW + SEL_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [RAW-1:0]        wr_addr,
   input  logic [AW-1:0]         wr_data,
   output logic [NB*AW-1:0]      base_all,
   output logic [NB*AW-1:0]      mask_all,
   output logic [NB-1:0]         valid_all,
   output logic [NB-1:0]         wprot_all,
   output logic [NB*TN*TW-1:0]   tim_all
);
   localparam logic [31:0] KEEP32 = hi_keep(AW, MINL);
   localparam logic [AW-1:0] KEEP = KEEP32[AW-1:0];

   logic [IDXW-1:0]  wbank;
   logic [SEL_W-1:0] wsel;
   assign wbank = wr_addr[RAW-1:SEL_W];
   assign wsel  = wr_addr[SEL_W-1:0];

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic [AW-1:0]         base_q, mask_q;
      logic                  valid_q, wprot_q;
      logic [TN-1:0][TW-1:0] tim_q;
      logic                  sel_me;
      assign sel_me = wr_en && (wbank == IDXW'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q <= (b == 0);
            base_q  <= (b == 0) ? (BOOT_BASE & KEEP) : '0;
            mask_q  <= (b == 0) ? (BOOT_MASK & KEEP) : '0;
            wprot_q <= 1'b0;
            tim_q   <= '0;
         end else if (sel_me) begin
            if (wsel == SEL_BASE) begin
               base_q  <= wr_data & KEEP;
               valid_q <= wr_data[0];
            end
            if (wsel == SEL_MASK) mask_q  <= wr_data & KEEP;
            if (wsel == SEL_OPT)  wprot_q <= wr_data[0];
            for (int t = 0; t < TN; t++)
               if (wsel == SEL_W'(int'(SEL_TIM0) + t)) tim_q[t] <= wr_data[TW-1:0];
         end
      end

      assign base_all[b*AW +: AW]        = base_q;
      assign mask_all[b*AW +: AW]        = mask_q;
      assign valid_all[b]                = valid_q;
      assign wprot_all[b]                = wprot_q;
      assign tim_all[b*TN*TW +: TN*TW]   = tim_q;
   end
endmodule

// File: rtl/csdec_match.sv
module csdec_match #(
   parameter int NB = 4,
   parameter int AW = 32
) (
   input  logic [AW-1:0]    addr,
   input  logic [NB*AW-1:0] base_all,
   input  logic [NB*AW-1:0] mask_all,
   input  logic [NB-1:0]    valid_all,
   output logic [NB-1:0]    hit
);
   for (genvar b = 0; b < NB; b++) begin : g_cmp
      logic [AW-1:0] diff;
      assign diff   = (addr ^ base_all[b*AW +: AW]) & mask_all[b*AW +: AW];
      assign hit[b] = valid_all[b] && (diff == '0);
   end
endmodule

// File: rtl/csdec_select.sv
module csdec_select #(
   parameter int NB   = 4,
   parameter int TN   = 4,
   parameter int TW   = 32,
   localparam int IDXW = $clog2(NB)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [NB-1:0]        hit,
   input  logic [NB-1:0]        wprot_all,
   input  logic [NB*TN*TW-1:0]  tim_all,
   output logic [NB-1:0]        cs_o,
   output logic [IDXW-1:0]      bank_o,
   output logic [TN*TW-1:0]     tim_o,
   output logic                 wp_err_o,
   output logic                 nomatch_err_o
);
   logic            found, blocked;
   logic [IDXW-1:0] win;

   always_comb begin
      found = 1'b0;
      win   = '0;
      for (int b = NB - 1; b >= 0; b--) begin
         if (hit[b]) begin
            found = 1'b1;
            win   = IDXW'(b);
         end
      end
      blocked = req_write && wprot_all[win];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_o          <= '0;
         bank_o        <= '0;
         tim_o         <= '0;
         wp_err_o      <= 1'b0;
         nomatch_err_o <= 1'b0;
      end else begin
         cs_o          <= (req_valid && found && !blocked) ? (NB'(1) << win) : '0;
         wp_err_o      <= req_valid && found && blocked;
         nomatch_err_o <= req_valid && !found;
         if (req_valid && found) begin
            bank_o <= win;
            tim_o  <= tim_all[win*TN*TW +: TN*TW];
         end
      end
   end
endmodule

// File: rtl/csdec_top.sv
module csdec_top
   import csdec_pkg::*;
#(
   parameter int NB        = 4,
   parameter int AW        = 32,
   parameter int TN        = 4,
   parameter int TW        = 32,
   parameter int MINL      = 16,
   parameter logic [AW-1:0] BOOT_BASE = 32'hFFFF_0000,
   parameter logic [AW-1:0] BOOT_MASK = 32'hFFFF_0000,
   localparam int IDXW     = $clog2(NB),
   localparam int RAW      = IDXW + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [AW-1:0]     req_addr,
   input  logic              req_write,
   input  logic              cfg_wr_en,
   input  logic [RAW-1:0]    cfg_addr,
   input  logic [AW-1:0]     cfg_wdata,
   output logic [NB-1:0]     cs_o,
   output logic [IDXW-1:0]   bank_o,
   output logic [TN*TW-1:0]  tim_o,
   output logic              wp_err_o,
   output logic              nomatch_err_o
);
   if (NB < 2 || NB > 8)         begin : g_bad_nb   $error("NB must be 2..8");          end
   if (NB != (1 << IDXW))        begin : g_bad_pow  $error("NB must be a power of 2");  end
   if (AW < 17 || AW > 32)       begin : g_bad_aw   $error("AW must be 17..32");        end
   if (TN < 1 || TN > 5)         begin : g_bad_tn   $error("TN must be 1..5");          end
   if (TW < 1 || TW > AW)        begin : g_bad_tw   $error("TW must be 1..AW");         end
   if (MINL < 1 || MINL >= AW)   begin : g_bad_minl $error("MINL out of range");        end

   logic [NB*AW-1:0]    base_all, mask_all;
   logic [NB-1:0]       valid_all, wprot_all, hit;
   logic [NB*TN*TW-1:0] tim_all;

   csdec_regfile #(
      .NB(NB), .AW(AW), .TN(TN), .TW(TW), .MINL(MINL),
      .BOOT_BASE(BOOT_BASE), .BOOT_MASK(BOOT_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
      .wr_data(cfg_wdata), .base_all(base_all), .mask_all(mask_all),
      .valid_all(valid_all), .wprot_all(wprot_all), .tim_all(tim_all)
   );

   csdec_match #(.NB(NB), .AW(AW)) u_match (
      .addr(req_addr), .base_all(base_all), .mask_all(mask_all),
      .valid_all(valid_all), .hit(hit)
   );

   csdec_select #(.NB(NB), .TN(TN), .TW(TW)) u_sel (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .hit(hit), .wprot_all(wprot_all), .tim_all(tim_all),
      .cs_o(cs_o), .bank_o(bank_o), .tim_o(tim_o),
      .wp_err_o(wp_err_o), .nomatch_err_o(nomatch_err_o)
   );
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk #(
   parameter int NB   = 4,
   parameter int AW   = 32,
   parameter int TN   = 4,
   parameter int TW   = 32,
   parameter int IDXW = 2,
   parameter int RAW  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [AW-1:0]     req_addr,
   input logic              req_write,
   input logic              cfg_wr_en,
   input logic [RAW-1:0]    cfg_addr,
   input logic [AW-1:0]     cfg_wdata,
   input logic [NB-1:0]     cs_o,
   input logic [IDXW-1:0]   bank_o,
   input logic [TN*TW-1:0]  tim_o,
   input logic              wp_err_o,
   input logic              nomatch_err_o
);
   // R4: never more than one chip select
   a_r4_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_o));

   // R8: results vanish after an idle request cycle
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (cs_o == '0 && !wp_err_o && !nomatch_err_o));

   // R5: a miss excludes a chip select and a protect error
   a_r5_miss_alone: assert property (@(posedge clk) disable iff (!rst_n)
      nomatch_err_o |-> (cs_o == '0 && !wp_err_o));

   // R6: reads never raise the protect error
   a_r6_read_no_wp: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> !wp_err_o);

   // R6: a protect error never comes with a chip select
   a_r6_wp_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
      wp_err_o |-> cs_o == '0);

   // R7: bank and timing outputs hold without a request
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> ($stable(bank_o) && $stable(tim_o)));

   // R4: the driven chip select agrees with the reported bank
   a_r4_cs_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_o != '0) |-> cs_o[bank_o]);
endmodule

bind csdec_top csdec_chk #(
   .NB(NB), .AW(AW), .TN(TN), .TW(TW), .IDXW(IDXW), .RAW(RAW)
) u_chk (.*);

// File: tb/sim_csdec_top.sv
`timescale 1ns/1ps
module sim_csdec_top;
   localparam int NB = 4, AW = 32, TN = 4, TW = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, cfg_wr_en = 1'b0;
   logic [31:0] req_addr = '0, cfg_wdata = '0;
   logic [4:0]  cfg_addr = '0;
   logic [3:0]  cs_o;
   logic [1:0]  bank_o;
   logic [127:0] tim_o;
   logic wp_err_o, nomatch_err_o;

   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   csdec_top u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_write(req_write), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cs_o(cs_o), .bank_o(bank_o), .tim_o(tim_o),
      .wp_err_o(wp_err_o), .nomatch_err_o(nomatch_err_o)
   );

   // reference model of the programmed state
   logic [31:0] m_base [NB], m_mask [NB], m_tim [NB][TN];
   logic        m_val [NB], m_wp [NB];
   logic [1:0]  e_bank = '0;
   logic [127:0] e_tim = '0;

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int b = 0; b < NB; b++) begin
         m_base[b] = (b == 0) ? 32'hFFFF_0000 : '0;
         m_mask[b] = (b == 0) ? 32'hFFFF_0000 : '0;
         m_val[b]  = (b == 0);
         m_wp[b]   = 1'b0;
         for (int t = 0; t < TN; t++) m_tim[b][t] = '0;
      end
   endtask

   task automatic cfg(input int b, input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_addr  = 5'((b << 3) | sel);
      cfg_wdata = d;
      case (sel)
         0: begin m_base[b] = d & 32'hFFFF_0000; m_val[b] = d[0]; end
         1: m_mask[b] = d & 32'hFFFF_0000;
         2: m_wp[b] = d[0];
         3, 4, 5, 6: m_tim[b][sel-3] = d;
         default: ;
      endcase
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   function automatic logic [31:0] size_mask(input int lg);
      logic [63:0] v;
      v = ~((64'd1 << lg) - 64'd1);
      return v[31:0];
   endfunction

   // issue one request and check all outputs one cycle later
   task automatic access(input logic [31:0] a, input logic wr, input string tag);
      int win;
      logic [3:0] e_cs;
      logic e_wp, e_nm;
      win = -1;
      for (int b = NB - 1; b >= 0; b--)
         if (m_val[b] && (((a ^ m_base[b]) & m_mask[b]) == 0)) win = b;
      e_cs = '0; e_wp = 1'b0; e_nm = (win < 0);
      if (win >= 0) begin
         e_bank = 2'(win);
         for (int t = 0; t < TN; t++) e_tim[t*TW +: TW] = m_tim[win][t];
         if (wr && m_wp[win]) e_wp = 1'b1;
         else e_cs = 4'(1 << win);
      end
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      chk({tag, " cs"},      128'(cs_o), 128'(e_cs));
      chk({tag, " wp"},      128'(wp_err_o), 128'(e_wp));
      chk({tag, " nomatch"}, 128'(nomatch_err_o), 128'(e_nm));
      chk({tag, " bank"},    128'(bank_o), 128'(e_bank));
      chk({tag, " tim"},     tim_o, e_tim);
   endtask

   task automatic idle_check(input string tag);
      @(negedge clk);
      chk({tag, " idle cs"}, 128'(cs_o), 128'(0));
      chk({tag, " idle pulses"}, 128'({wp_err_o, nomatch_err_o}), 128'(0));
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL R8 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 reset cs", 128'(cs_o), 128'(0));
      chk("R1 reset flags", 128'({wp_err_o, nomatch_err_o, bank_o}), 128'(0));
      chk("R1 reset tim", tim_o, 128'(0));
      rst_n = 1'b1;

      access(32'hFFFF_1234, 1'b0, "R1 boot hit");
      access(32'hFFFE_FFFF, 1'b0, "R1 below boot");
      idle_check("R5 miss pulse");
      access(32'h1234_5678, 1'b1, "R5 miss");
      idle_check("R8 after miss");

      // bank 1: 64KB at 0x40000000 with timing words
      cfg(1, 1, 32'hFFFF_0000);
      cfg(1, 0, 32'h4000_0001);
      for (int t = 0; t < TN; t++) cfg(1, 3 + t, 32'hA0A0_0000 + t);
      cfg(1, 7, 32'hFFFF_FFFF); // R9 unused selector
      access(32'h4000_FFFF, 1'b0, "R3 top of 64KB");
      access(32'h4001_0000, 1'b0, "R3 just past 64KB");
      access(32'h4000_0000, 1'b0, "R7 R9 timing words");

      // bank 2: low mask bits ignored, still 64KB
      cfg(2, 1, 32'hFFFF_FFFF);
      cfg(2, 0, 32'h8000_FFFF);
      access(32'h8000_ABCD, 1'b0, "R3 mask low bits ignored");
      access(32'h8001_0000, 1'b0, "R2 R3 outside bank2");

      // bank 3: whole space
      cfg(3, 1, 32'h0000_0000);
      cfg(3, 0, 32'h1234_0001);
      for (int t = 0; t < TN; t++) cfg(3, 3 + t, 32'h3333_0000 + t);
      access(32'h0000_1234, 1'b0, "R3 4GB bank");
      access(32'h4000_0040, 1'b0, "R4 lowest wins");
      access(32'hFFFF_0000, 1'b0, "R4 bank0 over bank3");

      // write protect on bank 1
      cfg(1, 2, 32'h0000_0001);
      access(32'h4000_0010, 1'b1, "R6 protected write");
      access(32'h4000_0010, 1'b0, "R6 protected read");
      idle_check("R8 after wp");

      // disable bank 3
      cfg(3, 0, 32'h1234_0000);
      access(32'h0000_1234, 1'b0, "R10 disabled bank");

      // random phase
      for (int round = 0; round < 20; round++) begin
         for (int b = 0; b < NB; b++) begin
            int lg;
            lg = 16 + int'($urandom_range(16));
            cfg(b, 1, size_mask(lg) | ($urandom() & 32'h0000_FFFF));
            cfg(b, 0, $urandom());
            cfg(b, 2, $urandom() & 32'h1);
            cfg(b, 3 + int'($urandom_range(TN - 1)), $urandom());
         end
         for (int n = 0; n < 30; n++) begin
            int pick;
            logic [31:0] a;
            pick = int'($urandom_range(NB));
            a = $urandom();
            if (pick < NB) a = (m_base[pick] & m_mask[pick]) | (a & ~m_mask[pick]);
            access(a, 1'($urandom_range(1)), "R2 R4 R6 R7 random");
            if ($urandom_range(3) == 0) idle_check("R8 random idle");
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule